// File: doc/BRIEF.md
# Watchdog Timer with Guarded Turn-Off

This block is a watchdog timer whose counter runs in its own slow clock domain (nominally 1 MHz). Software configures it through simple register writes issued on the bus clock. A 3-bit period select picks one of eight timeout lengths. Each length is a power of two of watchdog clock cycles. A kick pulse on the bus side stands for the software "I am alive" command and restarts the count. If the selected period runs out with no kick, the block raises a reset request for exactly one watchdog clock cycle. The surrounding reset logic turns that request into a chip reset.

Turning the watchdog on takes a single write. Turning it off, or changing its period while it runs, takes a two-write unlock. The first write sets both the change-permit bit and the enable bit, which opens a short window of a few bus cycles. The following write is honoured only if it lands inside that window. Every other write made while the watchdog runs is dropped. The enable level, the kick and the period select reach the watchdog domain through a multi-flop synchronizer. The kick crosses as a toggle and becomes a pulse again on the far side.

Top module: `wdt_sentinel`

## Requirements
- R1: After bus reset, wd_on reads 0 and wd_sel reads 0, and rst_req stays low while no write is made.
- R2: While the watchdog is on and never kicked, rst_req pulses recur every 2^(BASE_EXP+s)+1 watchdog cycles, where s is the unsigned value of wd_sel (0 to 7): 2^(BASE_EXP+s) counting cycles plus the pulse cycle.
- R3: rst_req is high for exactly one watchdog cycle, and the count is zero while it is high.
- R4: A kick pulse, high for one bus cycle, clears the count within SYNC_STAGES+2 watchdog cycles. Kicks repeated faster than the selected period keep rst_req low.
- R5: While the watchdog is off, any write loads wd_on from wr_ena and wd_sel from wr_sel.
- R6: While the watchdog is on, a write with wr_chg=1 and wr_ena=1 arms a window and changes nothing else. A write that is sampled on bus cycles 1 to WIN_CYC after the arming write is applied in full and closes the window: wr_ena=0 turns the watchdog off, and wr_ena=1 keeps it on and loads wr_sel.
- R7: While the watchdog is on, a write with wr_ena=0 outside an armed window is ignored. This includes a write on cycle WIN_CYC+1 after arming. After such a write wd_on stays 1 and pulses continue.
- R8: While the watchdog is on and no window is armed, no write changes wd_sel, and the arming write does not change it either.
- R9: Turning the watchdog off clears the count. After it is turned on again, the first pulse comes no earlier than one full selected period.
- R10: Asserting wd_rst_n low clears the count and the synchronizers. After release, the first pulse comes no earlier than one full selected period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus clock for the control writes and the kick |
| bus_rst_n | input | 1 | Active-low asynchronous reset, bus domain |
| wd_clk | input | 1 | Watchdog clock from the dedicated slow oscillator |
| wd_rst_n | input | 1 | Active-low asynchronous chip reset, watchdog domain |
| wr_en | input | 1 | Control write strobe, one bus cycle per write |
| wr_chg | input | 1 | Change-permit bit of the write |
| wr_ena | input | 1 | Enable bit of the write |
| wr_sel | input | SEL_W | Period select of the write |
| kick | input | 1 | Restart-count command, one bus cycle per kick |
| wd_on | output | 1 | Current enable state (bus domain) |
| wd_sel | output | SEL_W | Current period select (bus domain) |
| rst_req | output | 1 | Reset request, one watchdog cycle per expiry |

## Verification
The assertions assume that two kicks are always at least SYNC_STAGES+1 watchdog cycles apart, so that two toggles never merge into no change. They also assume that the multi-bit period select only changes while the counter is idle or is being restarted, so a skewed capture can never be used. The bench spaces its kicks by a dozen watchdog cycles. It changes the period only through turn-off and turn-on, or through an unlock write, and then waits for several full periods before it measures anything. Both resets are applied at time zero and released away from the clock edges.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

   // action decoded from one control write on the bus side
   typedef enum logic [1:0] {
      WR_NONE  = 2'd0,
      WR_APPLY = 2'd1,
      WR_ARM   = 2'd2,
      WR_DROP  = 2'd3
   } wr_act_e;

   // counter width needed for the longest period (2^(base+2^sel_w-1) cycles)
   function automatic int cnt_width(input int base_exp, input int sel_w);
      return base_exp + (1 << sel_w) - 1;
   endfunction

   // window counter width able to hold win_cyc
   function automatic int win_width(input int win_cyc);
      return (win_cyc < 2) ? 1 : $clog2(win_cyc + 1);
   endfunction

endpackage

// File: rtl/wdt_sync.sv
module wdt_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   initial begin
      assert (STAGES >= 2) else $error("wdt_sync: STAGES must be at least 2");
      assert (W >= 1)      else $error("wdt_sync: W must be at least 1");
   end

   logic [W-1:0] stg [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[0] <= '0;
            else        stg[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[i] <= '0;
            else        stg[i] <= stg[i-1];
         end
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/wdt_bus_ctl.sv
module wdt_bus_ctl
   import wdt_pkg::*;
#(
   parameter int SEL_W   = 3,
   parameter int WIN_CYC = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             wr_chg,
   input  logic             wr_ena,
   input  logic [SEL_W-1:0] wr_sel,
   input  logic             kick,
   output logic             on_q,
   output logic [SEL_W-1:0] sel_q,
   output logic             win_open,
   output logic             kick_tgl
);

   localparam int WIN_W = win_width(WIN_CYC);

   initial begin
      assert (WIN_CYC >= 1) else $error("wdt_bus_ctl: WIN_CYC must be at least 1");
   end

   logic [WIN_W-1:0] win_q;
   wr_act_e          act;

   assign win_open = (win_q != '0);

   // classify the write against the current protection state
   always_comb begin
      act = WR_NONE;
      if (wr_en) begin
         if (!on_q || win_open)    act = WR_APPLY;
         else if (wr_chg && wr_ena) act = WR_ARM;
         else                       act = WR_DROP;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         on_q  <= 1'b0;
         sel_q <= '0;
         win_q <= '0;
      end else begin
         unique case (act)
            WR_APPLY: begin
               on_q  <= wr_ena;
               sel_q <= wr_sel;
               win_q <= '0;
            end
            WR_ARM:  win_q <= WIN_W'(WIN_CYC);
            default: if (win_open) win_q <= win_q - WIN_W'(1);
         endcase
      end
   end

   // kick crosses domains as a level toggle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    kick_tgl <= 1'b0;
      else if (kick) kick_tgl <= ~kick_tgl;
   end

endmodule

// File: rtl/wdt_tick.sv
module wdt_tick #(
   parameter int BASE_EXP = 14,
   parameter int SEL_W    = 3,
   parameter int CNT_W    = 21
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             tgl,
   input  logic [SEL_W-1:0] sel,
   output logic [CNT_W-1:0] cnt,
   output logic             kick_p,
   output logic             rst_req
);

   localparam int NPER = 1 << SEL_W;

   initial begin
      assert (CNT_W == BASE_EXP + NPER - 1)
         else $error("wdt_tick: CNT_W does not match BASE_EXP and SEL_W");
   end

   logic            tgl_d;
   logic [NPER-1:0] reach;
   logic            expire;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tgl_d <= 1'b0;
      else        tgl_d <= tgl;
   end

   assign kick_p = tgl ^ tgl_d;

   // one terminal comparator per period; >= so a shortened period still fires
   for (genvar i = 0; i < NPER; i++) begin : g_term
      localparam logic [CNT_W-1:0] TERM = {CNT_W{1'b1}} >> (NPER - 1 - i);
      assign reach[i] = (cnt >= TERM);
   end

   assign expire = reach[sel];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         rst_req <= 1'b0;
      end else if (!en) begin
         cnt     <= '0;
         rst_req <= 1'b0;
      end else if (rst_req) begin
         cnt     <= '0;
         rst_req <= 1'b0;
      end else if (kick_p) begin
         cnt     <= '0;
      end else if (expire) begin
         cnt     <= '0;
         rst_req <= 1'b1;
      end else begin
         cnt     <= cnt + CNT_W'(1);
      end
   end

endmodule

// File: rtl/wdt_sentinel.sv
module wdt_sentinel #(
   parameter int BASE_EXP    = 14,
   parameter int SEL_W       = 3,
   parameter int WIN_CYC     = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic             bus_clk,
   input  logic             bus_rst_n,
   input  logic             wd_clk,
   input  logic             wd_rst_n,
   input  logic             wr_en,
   input  logic             wr_chg,
   input  logic             wr_ena,
   input  logic [SEL_W-1:0] wr_sel,
   input  logic             kick,
   output logic             wd_on,
   output logic [SEL_W-1:0] wd_sel,
   output logic             rst_req
);

   localparam int CNT_W = wdt_pkg::cnt_width(BASE_EXP, SEL_W);
   localparam int XW    = SEL_W + 2;

   initial begin
      assert (BASE_EXP >= 1)              else $error("wdt_sentinel: BASE_EXP too small");
      assert (SEL_W >= 1 && SEL_W <= 4)   else $error("wdt_sentinel: SEL_W out of range");
      assert (CNT_W <= 48)                else $error("wdt_sentinel: counter too wide");
      assert (SYNC_STAGES >= 2)           else $error("wdt_sentinel: need two sync stages");
   end

   logic             win_open;
   logic             kick_tgl;
   logic             en_w;
   logic             tgl_w;
   logic [SEL_W-1:0] sel_w;
   logic [CNT_W-1:0] cnt;
   logic             kick_w;

   wdt_bus_ctl #(.SEL_W(SEL_W), .WIN_CYC(WIN_CYC)) u_ctl (
      .clk      (bus_clk),
      .rst_n    (bus_rst_n),
      .wr_en    (wr_en),
      .wr_chg   (wr_chg),
      .wr_ena   (wr_ena),
      .wr_sel   (wr_sel),
      .kick     (kick),
      .on_q     (wd_on),
      .sel_q    (wd_sel),
      .win_open (win_open),
      .kick_tgl (kick_tgl)
   );

   wdt_sync #(.W(XW), .STAGES(SYNC_STAGES)) u_xing (
      .clk   (wd_clk),
      .rst_n (wd_rst_n),
      .d     ({wd_on, kick_tgl, wd_sel}),
      .q     ({en_w, tgl_w, sel_w})
   );

   wdt_tick #(.BASE_EXP(BASE_EXP), .SEL_W(SEL_W), .CNT_W(CNT_W)) u_tick (
      .clk     (wd_clk),
      .rst_n   (wd_rst_n),
      .en      (en_w),
      .tgl     (tgl_w),
      .sel     (sel_w),
      .cnt     (cnt),
      .kick_p  (kick_w),
      .rst_req (rst_req)
   );

endmodule

// File: rtl/wdt_sentinel_chk.sv
module wdt_sentinel_chk #(
   parameter int SEL_W = 3,
   parameter int CNT_W = 21
) (
   input logic             bus_clk,
   input logic             bus_rst_n,
   input logic             wd_clk,
   input logic             wd_rst_n,
   input logic             wr_en,
   input logic             wr_ena,
   input logic             wd_on,
   input logic [SEL_W-1:0] wd_sel,
   input logic             win_open,
   input logic             en_w,
   input logic             kick_w,
   input logic [CNT_W-1:0] cnt,
   input logic             rst_req
);

   // R3
   rst_single_chk: assert property (@(posedge wd_clk) disable iff (!wd_rst_n)
      rst_req |=> !rst_req);

   // R3
   rst_zero_cnt_chk: assert property (@(posedge wd_clk) disable iff (!wd_rst_n)
      rst_req |-> (cnt == '0));

   // R2
   rst_needs_on_chk: assert property (@(posedge wd_clk) disable iff (!wd_rst_n)
      rst_req |-> $past(en_w));

   // R4
   kick_clears_chk: assert property (@(posedge wd_clk) disable iff (!wd_rst_n)
      (kick_w && en_w) |=> (cnt == '0));

   // R9
   off_clears_chk: assert property (@(posedge wd_clk) disable iff (!wd_rst_n)
      !en_w |=> ((cnt == '0) && !rst_req));

   // R6
   guarded_off_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
      $fell(wd_on) |-> $past(win_open && wr_en && !wr_ena));

   // R5
   on_by_write_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
      $rose(wd_on) |-> $past(wr_en && wr_ena));

   // R8
   sel_locked_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
      (wd_on && !win_open) |=> $stable(wd_sel));

endmodule

bind wdt_sentinel wdt_sentinel_chk #(.SEL_W(SEL_W), .CNT_W(CNT_W)) u_chk (
   .bus_clk   (bus_clk),
   .bus_rst_n (bus_rst_n),
   .wd_clk    (wd_clk),
   .wd_rst_n  (wd_rst_n),
   .wr_en     (wr_en),
   .wr_ena    (wr_ena),
   .wd_on     (wd_on),
   .wd_sel    (wd_sel),
   .win_open  (win_open),
   .en_w      (en_w),
   .kick_w    (kick_w),
   .cnt       (cnt),
   .rst_req   (rst_req)
);

// File: tb/sim_wdt_sentinel.sv
`timescale 1ns/1ps
module sim_wdt_sentinel;

   localparam int BASE = 3;
   localparam int SW   = 3;
   localparam int WIN  = 4;

   logic          bus_clk = 1'b0;
   logic          wd_clk  = 1'b0;
   logic          bus_rst_n = 1'b0;
   logic          wd_rst_n  = 1'b0;
   logic          wr_en = 1'b0, wr_chg = 1'b0, wr_ena = 1'b0, kick = 1'b0;
   logic [SW-1:0] wr_sel = '0;
   logic          wd_on;
   logic [SW-1:0] wd_sel;
   logic          rst_req;

   int checks = 0;
   int fails  = 0;

   int unsigned wcyc = 0, pcount = 0, plast = 0, pgap = 0, wide = 0;
   logic        prev_rr = 1'b0;

   always #2  bus_clk = ~bus_clk;
   always #10 wd_clk  = ~wd_clk;

   wdt_sentinel #(.BASE_EXP(BASE), .SEL_W(SW), .WIN_CYC(WIN), .SYNC_STAGES(2)) u0 (
      .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .wd_clk(wd_clk), .wd_rst_n(wd_rst_n),
      .wr_en(wr_en), .wr_chg(wr_chg), .wr_ena(wr_ena), .wr_sel(wr_sel), .kick(kick),
      .wd_on(wd_on), .wd_sel(wd_sel), .rst_req(rst_req)
   );

   // watchdog-domain monitor: cycle count, pulse times and gaps
   always @(posedge wd_clk) wcyc = wcyc + 1;
   always @(negedge wd_clk) begin
      if (rst_req === 1'b1) begin
         if (prev_rr) wide = wide + 1;
         pgap   = wcyc - plast;
         plast  = wcyc;
         pcount = pcount + 1;
      end
      prev_rr = (rst_req === 1'b1);
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge bus_clk);
   endtask

   task automatic wd_idle(input int n);
      repeat (n) @(negedge wd_clk);
   endtask

   // called at a bus negedge; write is sampled on the next rising edge
   task automatic wr(input bit c, input bit e, input logic [SW-1:0] s);
      wr_en = 1'b1; wr_chg = c; wr_ena = e; wr_sel = s;
      @(negedge bus_clk);
      wr_en = 1'b0; wr_chg = 1'b0; wr_ena = 1'b0;
   endtask

   task automatic do_kick();
      kick = 1'b1;
      @(negedge bus_clk);
      kick = 1'b0;
   endtask

   task automatic turn_off();
      wr(1'b1, 1'b1, '0);
      wr(1'b0, 1'b0, '0);
   endtask

   task automatic wait_pulses(input int n, input string req);
      int unsigned target = pcount + n;
      int guard = 0;
      while (pcount < target && guard < 4000) begin
         @(negedge wd_clk);
         guard++;
      end
      chk(pcount >= target, req, "pulse arrival", int'(pcount), int'(target));
   endtask

   function automatic int period(input int s);
      return 1 << (BASE + s);
   endfunction

   task automatic t_reset();
      idle(1);
      chk(wd_on == 1'b0, "R1", "wd_on after reset", int'(wd_on), 0);
      chk(wd_sel == '0, "R1", "wd_sel after reset", int'(wd_sel), 0);
      wd_idle(100);
      chk(pcount == 0, "R1", "pulses while off", int'(pcount), 0);
   endtask

   task automatic t_periods();
      int sels[3] = '{0, 3, 7};
      foreach (sels[k]) begin
         @(negedge bus_clk);
         wr(1'b0, 1'b1, SW'(sels[k]));
         chk(wd_on == 1'b1 && wd_sel == SW'(sels[k]), "R5", "enable write loads sel",
             int'(wd_sel), sels[k]);
         wait_pulses(3, "R2");
         chk(pgap == period(sels[k]) + 1, "R2", "pulse spacing", int'(pgap),
             period(sels[k]) + 1);
         @(negedge bus_clk);
         turn_off();
         chk(wd_on == 1'b0, "R6", "arm then immediate off", int'(wd_on), 0);
         wd_idle(4);
      end
      chk(wide == 0, "R3", "rst_req width over 1 cycle", int'(wide), 0);
   endtask

   task automatic t_sel_via_window();
      @(negedge bus_clk);
      wr(1'b0, 1'b1, SW'(0));
      wait_pulses(1, "R2");
      @(negedge bus_clk);
      wr(1'b1, 1'b1, SW'(5));
      chk(wd_sel == SW'(0), "R8", "arming write keeps sel", int'(wd_sel), 0);
      wr(1'b0, 1'b1, SW'(1));
      chk(wd_on == 1'b1 && wd_sel == SW'(1), "R6", "window write loads sel",
          int'(wd_sel), 1);
      wait_pulses(3, "R6");
      chk(pgap == period(1) + 1, "R6", "spacing after window sel change", int'(pgap),
          period(1) + 1);
   endtask

   task automatic t_window_edges();
      // still on, sel 1: arm, write on 4th cycle -> accepted
      @(negedge bus_clk);
      wr(1'b1, 1'b1, SW'(1));
      idle(WIN - 1);
      wr(1'b0, 1'b0, SW'(1));
      chk(wd_on == 1'b0, "R6", "off write on last window cycle", int'(wd_on), 0);
      wr(1'b0, 1'b1, SW'(2));
      // arm, write on 5th cycle -> dropped
      wr(1'b1, 1'b1, SW'(2));
      idle(WIN);
      wr(1'b0, 1'b0, SW'(2));
      chk(wd_on == 1'b1, "R7", "off write one cycle late", int'(wd_on), 1);
      // stray writes without arming
      idle(6);
      wr(1'b0, 1'b0, SW'(6));
      chk(wd_on == 1'b1, "R7", "unarmed off write", int'(wd_on), 1);
      chk(wd_sel == SW'(2), "R8", "unarmed write keeps sel", int'(wd_sel), 2);
      wr(1'b1, 1'b0, SW'(4));
      chk(wd_on == 1'b1 && wd_sel == SW'(2), "R7", "change bit without enable",
          int'(wd_on), 1);
      wait_pulses(2, "R7");
      chk(pgap == period(2) + 1, "R7", "pulses continue after stray writes",
          int'(pgap), period(2) + 1);
   endtask

   task automatic t_kick();
      int unsigned p0;
      // on, sel 2 (period 32 wd cycles)
      @(negedge bus_clk);
      turn_off();
      wr(1'b0, 1'b1, SW'(2));
      do_kick();
      p0 = pcount;
      for (int i = 0; i < 20; i++) begin
         idle(60);
         do_kick();
      end
      chk(pcount == p0, "R4", "kicked watchdog stays quiet", int'(pcount), int'(p0));
      wait_pulses(1, "R4");
   endtask

   task automatic t_off_clears();
      int unsigned t0;
      int d;
      int unsigned p0;
      @(negedge bus_clk);
      turn_off();
      wr(1'b0, 1'b1, SW'(3));
      wait_pulses(1, "R9");
      wd_idle(50);
      @(negedge bus_clk);
      turn_off();
      p0 = pcount;
      wd_idle(10);
      chk(pcount == p0, "R9", "no pulse while off", int'(pcount), int'(p0));
      @(negedge bus_clk);
      wr(1'b0, 1'b1, SW'(3));
      t0 = wcyc;
      wait_pulses(1, "R9");
      d = int'(plast - t0);
      chk(d >= period(3) && d <= period(3) + 5, "R9", "first pulse after re-enable",
          d, period(3) + 2);
   endtask

   task automatic t_chip_reset();
      int unsigned t0;
      int d;
      wait_pulses(1, "R10");
      wd_idle(40);
      wd_rst_n = 1'b0;
      wd_idle(3);
      wd_rst_n = 1'b1;
      t0 = wcyc;
      wait_pulses(1, "R10");
      d = int'(plast - t0);
      chk(d >= period(3) && d <= period(3) + 5, "R10", "first pulse after chip reset",
          d, period(3) + 2);
   endtask

   task automatic run_all();
      #13;
      bus_rst_n = 1'b1;
      wd_rst_n  = 1'b1;
      t_reset();
      t_periods();
      t_sel_via_window();
      t_window_edges();
      t_kick();
      t_off_clears();
      t_chip_reset();
   endtask

   initial begin
      fork
         run_all();
         begin
            repeat (150000) @(posedge bus_clk);
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      disable fork;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule